// File: doc/BRIEF.md
# Direction-Gated Dual-Rate Time Counter

This block keeps two elapsed-time counters for a battery current path: one totals time spent charging, the other totals time spent discharging. A free-running prescaler divides the system clock into a one-cycle base tick, nominally one every 0.8789 s, which is 4096 per hour. On each base tick, the counter that matches the present current direction advances. When direction is idle, nothing moves.

When a counter wraps past its all-ones value, it raises a sticky slow-mode flag for its own channel. From then on, that counter advances only once per 256 qualifying ticks, which is about one count per 225 s or 16 per hour. An 8-bit divider per channel counts those ticks. A write-one-to-clear strobe removes a flag and also restarts the divider for that channel. The counter value is kept, and the counter goes back to the normal rate.

The current sensing that produces the direction code sits outside this block. The prescaler length is a parameter, so a bench can use a short tick.

Top module: `flow_time_counter`

## Requirements
- R1: While `rstN` is low, both counters read 0, both flags read 0 and `baseTick` is low.
- R2: `baseTick` is high for one clock in every `TICK_CYCLES` clocks. Its first pulse is seen `TICK_CYCLES-1` clocks after reset is released, whatever the direction code.
- R3: `chgTime` increases by exactly 1 on a base tick only while `dirCode` is 2'b01. Otherwise it holds.
- R4: `disTime` increases by exactly 1 on a base tick only while `dirCode` is 2'b10. Otherwise it holds.
- R5: With `dirCode` at 2'b00 or 2'b11, neither counter changes. Neither slow-rate divider advances either: slow-rate progress resumes from where it stopped.
- R6: A counter advancing from all ones wraps to 0. In the same step it sets its flag: bit 0 of `slowFlags` for charge and bit 1 for discharge.
- R7: While its flag is set, a counter advances once per 256 base ticks that occur in its own direction.
- R8: A flag stays set until a clock with `clrEn` high and the matching `clrMask` bit high. Other bits, or `clrMask` with `clrEn` low, leave it unchanged. A wrap in the same clock as a clear leaves the flag set.
- R9: Clearing a flag keeps the counter value and restores the normal one-count-per-tick rate. It also restarts that channel's slow divider from zero.
- R10: The two channels are independent: activity, wraps and clears on one never alter the other's counter or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirCode | input | 2 | Current direction: 01 charge, 10 discharge, 00 or 11 idle |
| clrEn | input | 1 | Flag clear write strobe |
| clrMask | input | 2 | Flags to clear when `clrEn` is high (bit 0 charge, bit 1 discharge) |
| baseTick | output | 1 | One-clock base-rate tick from the prescaler |
| chgTime | output | CNT_W | Charge time counter |
| disTime | output | CNT_W | Discharge time counter |
| slowFlags | output | 2 | Sticky slow-rate flags (bit 0 charge, bit 1 discharge) |

## Verification
The properties assume three things about the inputs and parameters:
- `TICK_CYCLES` is at least 2, so that a tick can never be followed by another tick on the next clock.
- `dirCode` is a level sampled at the clock, so its effect on a counter shows one clock later.
- A clear write is a single-clock strobe.

The bench changes direction and clear inputs only on falling edges and holds each direction across whole tick windows. It lines the one coincident clear-and-wrap case up on a negedge where the tick is already visible. To reach every wrap within the run length, the counters are narrowed to 10 bits and the tick to 3 clocks.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_CHG = 0;
  localparam int CH_DIS = 1;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_CHG  = 2'b01,
    DIR_DIS  = 2'b10,
    DIR_HOLD = 2'b11
  } dir_e;

  // control -> datapath strobes, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] advance;
    logic [NUM_CH-1:0] clear;
  } ftc_strobe_t;

endpackage

// File: rtl/ftc_ctrl.sv
module ftc_ctrl
  import ftc_pkg::*;
#(
  parameter int TICK_CYCLES = 8,
  parameter int SLOW_DIV    = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        dirCode,
  input  logic              clrEn,
  input  logic [NUM_CH-1:0] clrMask,
  input  logic [NUM_CH-1:0] slowFlags,
  output logic              baseTick,
  output ftc_strobe_t       strb
);

  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [NUM_CH-1:0] advVec;
  logic [NUM_CH-1:0] clrVec;

  // base-tick prescaler, free running out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign baseTick = (preCnt == PRE_LAST);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam dir_e CH_DIR = (ch == CH_CHG) ? DIR_CHG : DIR_DIS;

    logic [DIV_W-1:0] divQ;
    logic             active;
    logic             slotDone;

    assign active   = baseTick && (dir_e'(dirCode) == CH_DIR);
    assign slotDone = (divQ == DIV_LAST);
    assign clrVec[ch] = clrEn && clrMask[ch];
    assign advVec[ch] = active && (!slowFlags[ch] || slotDone);

    // slow-rate divider: counts qualifying ticks only while flagged
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divQ <= '0;
      end else if (clrVec[ch]) begin
        divQ <= '0;
      end else if (active && slowFlags[ch]) begin
        divQ <= slotDone ? '0 : divQ + 1'b1;
      end
    end
  end

  assign strb.advance = advVec;
  assign strb.clear   = clrVec;

endmodule

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ftc_strobe_t                   strb,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntOut,
  output logic [NUM_CH-1:0]             flagOut
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] cntQ;
    logic             flagQ;
    logic             wrapHit;

    assign wrapHit = strb.advance[ch] && (cntQ == '1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strb.advance[ch]) begin
        cntQ <= cntQ + 1'b1;
      end
    end

    // wrap outranks a same-cycle clear so the event is never lost
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
      end else if (wrapHit) begin
        flagQ <= 1'b1;
      end else if (strb.clear[ch]) begin
        flagQ <= 1'b0;
      end
    end

    assign cntOut[ch]  = cntQ;
    assign flagOut[ch] = flagQ;
  end

endmodule

// File: rtl/flow_time_counter.sv
module flow_time_counter
  import ftc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 8,
  parameter int SLOW_DIV    = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       dirCode,
  input  logic             clrEn,
  input  logic [1:0]       clrMask,
  output logic             baseTick,
  output logic [CNT_W-1:0] chgTime,
  output logic [CNT_W-1:0] disTime,
  output logic [1:0]       slowFlags
);

  ftc_strobe_t                  strb;
  logic [NUM_CH-1:0][CNT_W-1:0] cntBus;

  ftc_ctrl #(
    .TICK_CYCLES (TICK_CYCLES),
    .SLOW_DIV    (SLOW_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dirCode   (dirCode),
    .clrEn     (clrEn),
    .clrMask   (clrMask),
    .slowFlags (slowFlags),
    .baseTick  (baseTick),
    .strb      (strb)
  );

  ftc_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cntOut  (cntBus),
    .flagOut (slowFlags)
  );

  assign chgTime = cntBus[CH_CHG];
  assign disTime = cntBus[CH_DIS];

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       dirCode,
  input logic             clrEn,
  input logic [1:0]       clrMask,
  input logic             baseTick,
  input logic [CNT_W-1:0] chgTime,
  input logic [CNT_W-1:0] disTime,
  input logic [1:0]       slowFlags
);

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    baseTick |=> !baseTick);

  p_chg_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dirCode != 2'b01) |=> $stable(chgTime));

  p_chg_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (chgTime == $past(chgTime)) || (chgTime == $past(chgTime) + 1'b1));

  p_dis_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dirCode != 2'b10) |=> $stable(disTime));

  p_dis_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (disTime == $past(disTime)) || (disTime == $past(disTime) + 1'b1));

  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !baseTick |=> $stable(chgTime) && $stable(disTime));

  p_chg_flag_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowFlags[0]) |-> (chgTime == '0));

  p_dis_flag_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowFlags[1]) |-> (disTime == '0));

  p_chg_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slowFlags[0] && !(clrEn && clrMask[0])) |=> slowFlags[0]);

  p_dis_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slowFlags[1] && !(clrEn && clrMask[1])) |=> slowFlags[1]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (baseTick && dirCode == 2'b01 && !slowFlags[0] && chgTime == '1) |=> slowFlags[0]);

  initial begin
    p_tick_len_r2: assert (TICK_CYCLES >= 2);
  end

endmodule

bind flow_time_counter ftc_checker #(
  .CNT_W       (CNT_W),
  .TICK_CYCLES (TICK_CYCLES)
) u_chk (.*);

// File: tb/flow_time_counter_tb.sv
module flow_time_counter_tb;

  localparam int CW   = 10;
  localparam int TICK = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    dirCode;
  logic          clrEn;
  logic [1:0]    clrMask;
  logic          baseTick;
  logic [CW-1:0] chgTime;
  logic [CW-1:0] disTime;
  logic [1:0]    slowFlags;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  flow_time_counter #(
    .CNT_W       (CW),
    .TICK_CYCLES (TICK),
    .SLOW_DIV    (256)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .dirCode   (dirCode),
    .clrEn     (clrEn),
    .clrMask   (clrMask),
    .baseTick  (baseTick),
    .chgTime   (chgTime),
    .disTime   (disTime),
    .slowFlags (slowFlags)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // consume n base ticks; returns on the negedge after the last one took effect
  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      while (!baseTick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulseClear(input logic [1:0] mask, input logic en);
    clrEn   = en;
    clrMask = mask;
    @(negedge clk);
    clrEn   = 1'b0;
    clrMask = 2'b00;
  endtask

  task automatic testReset();
    rstN = 1'b0; dirCode = 2'b01; clrEn = 1'b0; clrMask = 2'b00;
    repeat (4) @(negedge clk);
    check("R1", "chgTime in reset", int'(chgTime), 0);
    check("R1", "disTime in reset", int'(disTime), 0);
    check("R1", "slowFlags in reset", int'(slowFlags), 0);
    check("R1", "baseTick in reset", int'(baseTick), 0);
    dirCode = 2'b00;
  endtask

  task automatic testTick();
    int k = 0;
    rstN = 1'b1;
    do begin @(negedge clk); k++; end while (!baseTick && k < 20);
    check("R2", "clocks to first tick", k, TICK - 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!baseTick && k < 20);
    check("R2", "tick spacing", k, TICK);
    @(negedge clk);
    check("R5", "chgTime idle after ticks", int'(chgTime), 0);
  endtask

  task automatic testCharge();
    dirCode = 2'b01;
    runTicks(5);
    check("R3", "chgTime after 5 charge ticks", int'(chgTime), 5);
    check("R10", "disTime during charge", int'(disTime), 0);
  endtask

  task automatic testDischarge();
    dirCode = 2'b10;
    runTicks(7);
    check("R4", "disTime after 7 discharge ticks", int'(disTime), 7);
    check("R4", "chgTime during discharge", int'(chgTime), 5);
  endtask

  task automatic testIdle();
    dirCode = 2'b00;
    runTicks(3);
    dirCode = 2'b11;
    runTicks(3);
    check("R5", "chgTime while idle", int'(chgTime), 5);
    check("R5", "disTime while idle", int'(disTime), 7);
  endtask

  task automatic testChgWrap();
    dirCode = 2'b01;
    runTicks((1 << CW) - 1 - 5);
    check("R6", "chgTime at all ones", int'(chgTime), (1 << CW) - 1);
    check("R6", "flags before wrap", int'(slowFlags), 0);
    runTicks(1);
    check("R6", "chgTime after wrap", int'(chgTime), 0);
    check("R6", "flags after charge wrap", int'(slowFlags), 1);
  endtask

  task automatic testChgSlow();
    runTicks(255);
    check("R7", "chgTime after 255 slow ticks", int'(chgTime), 0);
    dirCode = 2'b00;
    runTicks(10);
    dirCode = 2'b01;
    runTicks(1);
    check("R7", "chgTime after 256th slow tick (R5 divider frozen when idle)", int'(chgTime), 1);
  endtask

  task automatic testClearMask();
    dirCode = 2'b00;
    pulseClear(2'b11, 1'b0);
    check("R8", "flags after mask without enable", int'(slowFlags), 1);
    pulseClear(2'b10, 1'b1);
    check("R8", "flags after clearing other channel", int'(slowFlags), 1);
  endtask

  task automatic testClear();
    dirCode = 2'b01;
    runTicks(100);
    check("R7", "chgTime mid slow window", int'(chgTime), 1);
    dirCode = 2'b00;
    pulseClear(2'b01, 1'b1);
    check("R9", "flags after charge clear", int'(slowFlags), 0);
    check("R9", "chgTime kept across clear", int'(chgTime), 1);
    dirCode = 2'b01;
    runTicks(1);
    check("R9", "normal rate after clear", int'(chgTime), 2);
    runTicks((1 << CW) - 1 - 2);
    check("R9", "chgTime at all ones again", int'(chgTime), (1 << CW) - 1);
    while (!baseTick) @(negedge clk);
    pulseClear(2'b01, 1'b1);
    check("R8", "chgTime after wrap with clear", int'(chgTime), 0);
    check("R8", "wrap beats same-cycle clear", int'(slowFlags), 1);
    runTicks(255);
    check("R9", "divider restarted: no step at 255", int'(chgTime), 0);
    runTicks(1);
    check("R9", "divider restarted: step at 256", int'(chgTime), 1);
  endtask

  task automatic testDisWrap();
    dirCode = 2'b10;
    runTicks((1 << CW) - 1 - 7);
    check("R6", "disTime at all ones", int'(disTime), (1 << CW) - 1);
    check("R10", "flags before discharge wrap", int'(slowFlags), 1);
    runTicks(1);
    check("R6", "disTime after wrap", int'(disTime), 0);
    check("R6", "flags after discharge wrap", int'(slowFlags), 3);
    check("R10", "chgTime untouched by discharge", int'(chgTime), 1);
    runTicks(1);
    check("R7", "disTime slow after wrap", int'(disTime), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testTick();
    testCharge();
    testDischarge();
    testIdle();
    testChgWrap();
    testChgSlow();
    testClearMask();
    testClear();
    testDisWrap();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule